// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt and Wake Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32. Every register type holds one 32-bit word per bank. For each register type, the word for bank b sits at that type's base offset plus 4*b. Pin n is therefore bit n%32 of the word for bank n/32.

Software programs the following per pin:
- direction;
- the output latch, through write-only set and clear words;
- the detection mode: rising edge, falling edge, or active level with a polarity bit.

Detected events land in a sticky source register, which is cleared by writing 1. A mask selects which pending pins reach the single `irq_out` line. A separate wake-enable word routes events into a sticky wake-status word, which drives `wake_out`.

The register bus is a plain single-cycle port. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_en` is high. The bus never stalls, so it carries no back-pressure. Pin inputs pass through a two-flop synchronizer before they are seen by software or by the detectors.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, every readable word returns 0, and `pin_oe`, `pin_out`, `irq_out` and `wake_out` are all 0.
- R2: The direction word (0x01C + 4b) reads back as written. A bit of 1 drives the matching `pin_oe` bit high (output); 0 means input.
- R3: Writing 1 to a bit of the set word (0x034 + 4b) drives that `pin_out` bit high. Writing 1 to a bit of the clear word (0x04C + 4b) drives it low. Bits written 0 change nothing. Both words read as 0.
- R4: The level word (0x004 + 4b) returns `pin_in` delayed by two clock edges. Writes to it are ignored.
- R5: With the input-type bit at 0, the source bit (0x0C4 + 4b) sets on a rising edge when the rise-enable bit (0x064 + 4b) is 1. It sets on a falling edge when the fall-enable bit (0x07C + 4b) is 1. It is first readable after the third clock edge following the pin change.
- R6: With the input-type bit (0x300 + 4b) at 1, the source bit sets on every cycle the pin is active. Active means high when the polarity bit (0x318 + 4b) is 0, and low when it is 1.
- R7: Writing 1 to a source bit clears it, and bits written 0 stay unchanged. A new event in the same cycle as the clear wins.
- R8: `irq_out` is 1 exactly when some pin has both its source bit and its mask bit (0x0AC + 4b) at 1.
- R9: An event on a pin whose wake-enable bit (0x400 + 4b) is 1 sets its wake-status bit (0x418 + 4b). Writing 1 clears that status bit. `wake_out` is 1 while any wake-status bit is 1.
- R10: Pin n maps to bit n%32 of the word for bank n/32 in every register type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high |
| pin_in | input | NUM_BANKS*32 | Raw pin levels |
| pin_out | output | NUM_BANKS*32 | Output latch |
| pin_oe | output | NUM_BANKS*32 | Output enable (direction) |
| irq_out | output | 1 | Combined masked interrupt |
| wake_out | output | 1 | Combined wake request |

## Verification
The hardest case to reach from the ports is a write-1-clear of a source bit that lands in the same cycle as a fresh event on that pin. With edge detection, the two cannot be lined up without knowing the synchronizer latency to the cycle.

The bench instead puts pins into level mode with an active level held. An event then fires on every cycle, so every clear collides with one. The bench shows that the bit survives the clear, and that it survives in both polarities across both banks at once.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BANK_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_SET   = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_RISE  = 12'h064;
  localparam logic [ADDR_W-1:0] OFF_FALL  = 12'h07C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h0AC;
  localparam logic [ADDR_W-1:0] OFF_SRC   = 12'h0C4;
  localparam logic [ADDR_W-1:0] OFF_TYPE  = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_POL   = 12'h318;
  localparam logic [ADDR_W-1:0] OFF_WMASK = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_WSRC  = 12'h418;

  // per-bank write strobes, one per writable register type
  typedef struct packed {
    logic dir;
    logic set;
    logic clr;
    logic rise;
    logic fall;
    logic mask;
    logic src;
    logic itype;
    logic pol;
    logic wmask;
    logic wsrc;
  } wr_sel_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] itype,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev;
  logic [W-1:0] edge_hit;
  logic [W-1:0] level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  always_comb begin
    edge_hit  = (rise_en & lvl & ~prev) | (fall_en & ~lvl & prev);
    level_hit = lvl ^ pol;
    evt       = (itype & level_hit) | (~itype & edge_hit);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_sel_t      ws,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] src_q,
  output logic [W-1:0] type_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] wmask_q,
  output logic [W-1:0] wsrc_q
);
  logic [W-1:0] set_m, clr_m, src_clr, wsrc_clr;

  always_comb begin
    set_m    = ws.set  ? wdata : '0;
    clr_m    = ws.clr  ? wdata : '0;
    src_clr  = ws.src  ? wdata : '0;
    wsrc_clr = ws.wsrc ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      mask_q  <= '0;
      src_q   <= '0;
      type_q  <= '0;
      pol_q   <= '0;
      wmask_q <= '0;
      wsrc_q  <= '0;
    end else begin
      if (ws.dir)   dir_q   <= wdata;
      if (ws.rise)  rise_q  <= wdata;
      if (ws.fall)  fall_q  <= wdata;
      if (ws.mask)  mask_q  <= wdata;
      if (ws.itype) type_q  <= wdata;
      if (ws.pol)   pol_q   <= wdata;
      if (ws.wmask) wmask_q <= wdata;
      out_q  <= (out_q | set_m) & ~clr_m;
      // a fresh event outranks a clear in the same cycle
      src_q  <= (src_q & ~src_clr) | evt;
      wsrc_q <= (wsrc_q & ~wsrc_clr) | (evt & wmask_q);
    end
  end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_oe,
  output logic                          irq_out,
  output logic                          wake_out
);
  localparam int NPINS = NUM_BANKS * BANK_W;

  logic wr_en;
  logic [NUM_BANKS-1:0][BANK_W-1:0] lvl_a, evt_a, dir_a, out_a, rise_a, fall_a;
  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_a, src_a, type_a, pol_a, wmask_a, wsrc_a;

  assign wr_en = bus_en && bus_we;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_a)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4 * b);
    wr_sel_t ws;

    always_comb begin
      ws.dir   = wr_en && (bus_addr == OFF_DIR   + STEP);
      ws.set   = wr_en && (bus_addr == OFF_SET   + STEP);
      ws.clr   = wr_en && (bus_addr == OFF_CLR   + STEP);
      ws.rise  = wr_en && (bus_addr == OFF_RISE  + STEP);
      ws.fall  = wr_en && (bus_addr == OFF_FALL  + STEP);
      ws.mask  = wr_en && (bus_addr == OFF_MASK  + STEP);
      ws.src   = wr_en && (bus_addr == OFF_SRC   + STEP);
      ws.itype = wr_en && (bus_addr == OFF_TYPE  + STEP);
      ws.pol   = wr_en && (bus_addr == OFF_POL   + STEP);
      ws.wmask = wr_en && (bus_addr == OFF_WMASK + STEP);
      ws.wsrc  = wr_en && (bus_addr == OFF_WSRC  + STEP);
    end

    gpio_event_detect #(.W(BANK_W)) u_det (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_a[b]),
      .rise_en(rise_a[b]), .fall_en(fall_a[b]),
      .itype(type_a[b]), .pol(pol_a[b]), .evt(evt_a[b])
    );

    gpio_bank_regs #(.W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ws(ws), .wdata(bus_wdata), .evt(evt_a[b]),
      .dir_q(dir_a[b]), .out_q(out_a[b]), .rise_q(rise_a[b]), .fall_q(fall_a[b]),
      .mask_q(mask_a[b]), .src_q(src_a[b]), .type_q(type_a[b]), .pol_q(pol_a[b]),
      .wmask_q(wmask_a[b]), .wsrc_q(wsrc_a[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == OFF_LEVEL + ADDR_W'(4*b)) bus_rdata = lvl_a[b];
        if (bus_addr == OFF_DIR   + ADDR_W'(4*b)) bus_rdata = dir_a[b];
        if (bus_addr == OFF_RISE  + ADDR_W'(4*b)) bus_rdata = rise_a[b];
        if (bus_addr == OFF_FALL  + ADDR_W'(4*b)) bus_rdata = fall_a[b];
        if (bus_addr == OFF_MASK  + ADDR_W'(4*b)) bus_rdata = mask_a[b];
        if (bus_addr == OFF_SRC   + ADDR_W'(4*b)) bus_rdata = src_a[b];
        if (bus_addr == OFF_TYPE  + ADDR_W'(4*b)) bus_rdata = type_a[b];
        if (bus_addr == OFF_POL   + ADDR_W'(4*b)) bus_rdata = pol_a[b];
        if (bus_addr == OFF_WMASK + ADDR_W'(4*b)) bus_rdata = wmask_a[b];
        if (bus_addr == OFF_WSRC  + ADDR_W'(4*b)) bus_rdata = wsrc_a[b];
      end
    end
  end

  assign pin_out  = out_a;
  assign pin_oe   = dir_a;
  assign irq_out  = |(src_a & mask_a);
  assign wake_out = |wsrc_a;
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   bus_en,
  input logic                                   bus_we,
  input logic [ADDR_W-1:0]                      bus_addr,
  input logic [BANK_W-1:0]                      bus_wdata,
  input logic [NUM_BANKS*BANK_W-1:0]            pin_out,
  input logic [NUM_BANKS*BANK_W-1:0]            pin_oe,
  input logic                                   irq_out,
  input logic                                   wake_out,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]       mask_a,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]       wmask_a
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq_out && !wake_out));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OFF_DIR) |=> (pin_oe[BANK_W-1:0] == $past(bus_wdata)));

  p_set_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OFF_SET)
      |=> ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OFF_CLR)
      |=> ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == '0));

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_a != '0));

  p_wake_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_out) |-> ($past(wmask_a) != '0));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/gpio_banked_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_tb;
  import gpio_pkg::*;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_out, wake_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_banked_ctrl #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // samples combinational read data at the current negedge
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd64(input logic [11:0] base, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(base, lo);
    rd(base + 12'd4, hi);
    d = {hi, lo};
  endtask

  task automatic wr64(input logic [11:0] base, input logic [63:0] d);
    wr(base, d[31:0]);
    wr(base + 12'd4, d[63:32]);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, exp, pat, prev;
    logic [11:0] addrs [12];
    addrs = '{OFF_LEVEL, OFF_DIR, OFF_SET, OFF_CLR, OFF_RISE, OFF_FALL,
              OFF_MASK, OFF_SRC, OFF_TYPE, OFF_POL, OFF_WMASK, OFF_WSRC};
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1: reset state
    for (int i = 0; i < 12; i++) begin
      rd64(addrs[i], v);
      check("R1 register reset", v, 64'h0);
    end
    check("R1 pin_oe reset", pin_oe, 64'h0);
    check("R1 pin_out reset", pin_out, 64'h0);
    check("R1 irq/wake reset", {62'h0, irq_out, wake_out}, 64'h0);

    // R2 / R10: walking one across every pin of both banks
    for (int n = 0; n < NP; n++) begin
      exp = 64'h1 << n;
      wr(OFF_DIR + 12'(4 * (n / 32)), 32'h1 << (n % 32));
      wr(OFF_DIR + 12'(4 * (1 - n / 32)), 32'h0);
      @(negedge clk);
      check("R2 R10 pin_oe walk", pin_oe, exp);
      rd64(OFF_DIR, v);
      check("R2 dir readback", v, exp);
    end
    wr64(OFF_DIR, 64'h0);

    // R3 / R10: set accumulates, clear removes, zero bits inert
    exp = 64'h0;
    for (int n = 0; n < NP; n++) begin
      wr(OFF_SET + 12'(4 * (n / 32)), 32'h1 << (n % 32));
      exp = exp | (64'h1 << n);
      check("R3 R10 set walk", pin_out, exp);
    end
    wr64(OFF_SET, 64'h0);
    wr64(OFF_CLR, 64'h0);
    check("R3 zero write inert", pin_out, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int n = 0; n < NP; n += 3) begin
      wr(OFF_CLR + 12'(4 * (n / 32)), 32'h1 << (n % 32));
      exp = exp & ~(64'h1 << n);
      check("R3 clear walk", pin_out, exp);
    end
    rd64(OFF_SET, v);
    check("R3 set reads zero", v, 64'h0);
    rd64(OFF_CLR, v);
    check("R3 clear reads zero", v, 64'h0);
    wr64(OFF_CLR, 64'hFFFF_FFFF_FFFF_FFFF);

    // R4: two-edge synchronized level view, writes ignored
    prev = 64'h0;
    for (int k = 0; k < 6; k++) begin
      pat = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
      @(negedge clk);
      pin_in = pat;
      @(negedge clk);
      rd64(OFF_LEVEL, v);
      check("R4 level before second edge", v, prev);
      @(negedge clk);
      rd64(OFF_LEVEL, v);
      check("R4 level after second edge", v, pat);
      prev = pat;
    end
    wr64(OFF_LEVEL, ~prev);
    @(negedge clk);
    rd64(OFF_LEVEL, v);
    check("R4 level write ignored", v, prev);
    @(negedge clk);
    pin_in = '0;
    wait_n(4);
    wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);

    // R5: all four rise/fall enable combinations
    for (int m = 0; m < 4; m++) begin
      pat = 64'hA5C3_0F96_1234_8001 ^ (64'h0F0F_3C3C_5A5A_0FF0 * 64'(m));
      wr64(OFF_RISE, m[0] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
      wr64(OFF_FALL, m[1] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
      wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      pin_in = pat;
      wait_n(2);
      rd64(OFF_SRC, v);
      check("R5 no source before third edge", v, 64'h0);
      @(negedge clk);
      rd64(OFF_SRC, v);
      check("R5 rising source", v, m[0] ? pat : 64'h0);
      wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      pin_in = '0;
      wait_n(4);
      rd64(OFF_SRC, v);
      check("R5 falling source", v, m[1] ? pat : 64'h0);
      wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    wr64(OFF_RISE, 64'h0);
    wr64(OFF_FALL, 64'h0);

    // R7: zero bits of a clear leave pending bits alone
    wr64(OFF_FALL, 64'h0000_00F0_0000_000F);
    pin_in = 64'hFFFF_FFFF_FFFF_FFFF;
    wait_n(4);
    pin_in = '0;
    wait_n(4);
    wr64(OFF_SRC, 64'h0000_0030_0000_0003);
    rd64(OFF_SRC, v);
    check("R7 partial clear", v, 64'h0000_00C0_0000_000C);
    wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(OFF_SRC, v);
    check("R7 full clear", v, 64'h0);
    wr64(OFF_FALL, 64'h0);

    // R6 / R7: level mode, bank0 active high, bank1 active low
    wr64(OFF_POL, 64'hFFFF_FFFF_0000_0000);
    wr64(OFF_TYPE, 64'hFFFF_FFFF_FFFF_FFFF);
    pat = 64'h3C5A_9600_F00F_0A51;
    @(negedge clk);
    pin_in = pat;
    wait_n(4);
    wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(OFF_SRC, v);
    check("R6 R7 level survives clear", v, {~pat[63:32], pat[31:0]});
    wr64(OFF_TYPE, 64'h0);
    wr64(OFF_POL, 64'h0);
    wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(OFF_SRC, v);
    check("R6 clear after leaving level mode", v, 64'h0);
    @(negedge clk);
    pin_in = '0;
    wait_n(4);

    // R8: masked interrupt output
    wr64(OFF_RISE, 64'h0000_0300_0000_0000);
    pin_in = 64'h0000_0100_0000_0000;
    wait_n(4);
    check("R8 irq masked", {63'h0, irq_out}, 64'h0);
    wr64(OFF_MASK, 64'h0000_0008_0000_0000);
    check("R8 irq other mask bit", {63'h0, irq_out}, 64'h0);
    wr64(OFF_MASK, 64'h0000_0100_0000_0000);
    check("R8 irq enabled", {63'h0, irq_out}, 64'h1);
    wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 irq after clear", {63'h0, irq_out}, 64'h0);
    wr64(OFF_MASK, 64'h0);

    // R9: wake path, pins 40 and 41 rise, only 40 wake-enabled
    pin_in = '0;
    wait_n(4);
    wr64(OFF_SRC, 64'hFFFF_FFFF_FFFF_FFFF);
    wr64(OFF_WMASK, 64'h0000_0100_0000_0000);
    check("R9 wake idle", {63'h0, wake_out}, 64'h0);
    @(negedge clk);
    pin_in = 64'h0000_0300_0000_0000;
    wait_n(4);
    rd64(OFF_WSRC, v);
    check("R9 wake status", v, 64'h0000_0100_0000_0000);
    check("R9 wake asserted", {63'h0, wake_out}, 64'h1);
    wr64(OFF_WSRC, 64'h0000_0100_0000_0000);
    check("R9 wake cleared", {63'h0, wake_out}, 64'h0);
    rd64(OFF_WSRC, v);
    check("R9 wake status cleared", v, 64'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule